// File: doc/BRIEF.md
# Fractional Timer Tick Prescaler

This block turns a stream of input clock-enable cycles into a slower stream of tick strobes. A free-running 64-bit timer count advances on those ticks. The ratio is set by a 32-bit divisor word. Each enabled input cycle adds 2^31 to a phase accumulator. Whenever the accumulator reaches the divisor, one tick is produced and the divisor is subtracted. The tick rate is therefore the input rate times 2^31 divided by the divisor. A divisor of 0x80000000 gives one tick per input cycle, and larger values give proportionally fewer ticks.

Two clock-enable inputs stand in for two timer sources, the crystal reference and an alternate source. A control bit picks which of them feeds the accumulator, so the whole design runs on one clock. A second control bit doubles the amount the counter adds per tick. Software writes the control word and the divisor word through a simple write port: a write strobe, a 4-bit address and 32 bits of data.

Top module: `tick_prescaler_top`

## Requirements
- R1: After reset, `tick` is 0, `count` is 0, `step` is 1, the divisor is 0x80000000 and the source is the reference enable.
- R2: With the divisor at 0x80000000, every cycle in which the selected enable is high at a rising edge produces `tick` high during the following cycle, and `tick` is low otherwise.
- R3: With the divisor P written and then N enabled cycles applied, exactly floor(N*2^31/P) ticks occur. At most one tick follows each enabled cycle, and no tick follows a cycle without enable.
- R4: A divisor write with a value below 0x80000000, including 0, behaves as a write of 0x80000000.
- R5: A write to address 0x0 loads the control word. Its bit 9 selects the step: 0 makes `step` 1, and 1 makes `step` 2.
- R6: Control bit 8 selects the source. With bit 8 at 0, `ref_en` drives the accumulator and `alt_en` has no effect. With bit 8 at 1, `alt_en` drives it and `ref_en` has no effect. Writing 0 to the control word restores the reference source with step 1.
- R7: A write to address 0x8 loads the divisor and clears the accumulator to 0. No tick follows the write cycle.
- R8: `count` grows by the current `step` in the cycle after each `tick` cycle and holds its value otherwise.
- R9: Writes to any address other than 0x0 and 0x8 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0x0 control, 0x8 divisor |
| wr_data | input | 32 | Write data |
| ref_en | input | 1 | Reference source clock-enable |
| alt_en | input | 1 | Alternate source clock-enable |
| tick | output | 1 | One-cycle tick strobe |
| step | output | 2 | Amount added to the counter per tick |
| count | output | 64 | Free-running timer count |

## Verification
The main ratio is tried with several divisors and counts of enabled cycles. The unity divisor and the maximum 0xFFFFFFFF separate an exact-division model from one that rounds. The divisors 0xA0000000 and 0xC0000000 expose wrong remainder handling in the accumulator. Sub-unity values of 0x40000000 and 0 show whether the clamp is present. A doubled-step run separates the tick count from the count increment. Separate directed runs cover the following:
- a prescaler rewrite in mid-phase, which shows whether the accumulator is cleared;
- pulses on the deselected enable, which show that source selection works;
- writes to unused addresses, which must change nothing.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_DIV   = 4'h8;
    localparam int                CTRL_SRC_BIT  = 8;
    localparam int                CTRL_STEP_BIT = 9;
    localparam logic [DATA_W-1:0] UNITY_DIV = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic step_dbl;
        logic src_alt;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] clamp_div(input logic [DATA_W-1:0] v);
        return (v < UNITY_DIV) ? UNITY_DIV : v;
    endfunction

    function automatic logic [1:0] step_of(input ctrl_t c);
        return c.step_dbl ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] div_o,
    output logic          div_wr_o
);

    logic ctrl_hit;
    logic div_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);
    assign div_hit  = wr_en && (wr_addr == ADDR_DIV);
    assign div_wr_o = div_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            div_o  <= UNITY_DIV;
        end else begin
            if (ctrl_hit) begin
                ctrl_o.step_dbl <= wr_data[CTRL_STEP_BIT];
                ctrl_o.src_alt  <= wr_data[CTRL_SRC_BIT];
            end
            if (div_hit) begin
                div_o <= clamp_div(wr_data);
            end
        end
    end

    // R4
    div_min_chk: assert property (@(posedge clk) disable iff (rst)
        div_o >= UNITY_DIV);

endmodule

// File: rtl/tick_accum.sv
module tick_accum
    import tick_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [DW-1:0] div_i,
    output logic          tick_o
);

    localparam logic [DW:0] INC = {2'b01, {(DW-1){1'b0}}};

    logic [DW-1:0] acc_q;
    logic [DW:0]   sum;
    logic          fire;

    assign sum  = {1'b0, acc_q} + INC;
    assign fire = (sum >= {1'b0, div_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (clr_i) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (en_i) begin
            acc_q  <= fire ? DW'(sum - {1'b0, div_i}) : sum[DW-1:0];
            tick_o <= fire;
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R3
    tick_src_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(en_i && !clr_i));

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q < div_i);

    // R7
    clr_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !tick_o);

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [1:0]    step_i,
    output logic [CW-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (tick_i) begin
            count_o <= count_o + CW'(step_i);
        end
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (count_o == $past(count_o) + CW'($past(step_i))));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));

endmodule

// File: rtl/tick_prescaler_top.sv
module tick_prescaler_top
    import tick_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ref_en,
    input  logic          alt_en,
    output logic          tick,
    output logic [1:0]    step,
    output logic [CW-1:0] count
);

    ctrl_t         ctrl;
    logic [DW-1:0] div_val;
    logic          div_wr;
    logic          src_en;

    assign src_en = ctrl.src_alt ? alt_en : ref_en;
    assign step   = step_of(ctrl);

    tick_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_o   (ctrl),
        .div_o    (div_val),
        .div_wr_o (div_wr)
    );

    tick_accum #(.DW(DW)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .en_i   (src_en),
        .clr_i  (div_wr),
        .div_i  (div_val),
        .tick_o (tick)
    );

    tick_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .step_i  (step),
        .count_o (count)
    );

    // R6
    src_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && !alt_en) |=> !tick);

endmodule

// File: tb/tick_prescaler_top_test.sv
module tick_prescaler_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ref_en = 1'b0;
    logic        alt_en = 1'b0;
    logic        tick;
    logic [1:0]  step;
    logic [63:0] count;

    int tests = 0;
    int fails = 0;
    int ticks_seen = 0;

    always #5 clk = ~clk;

    tick_prescaler_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ref_en(ref_en), .alt_en(alt_en),
        .tick(tick), .step(step), .count(count)
    );

    always @(negedge clk) if (!rst && tick) ticks_seen++;

    localparam int NV = 7;
    localparam logic [31:0] V_DIV [NV] = '{32'h8000_0000, 32'hC000_0000,
        32'hA000_0000, 32'hFFFF_FFFF, 32'h4000_0000, 32'h0000_0000, 32'h8000_0000};
    localparam logic V_DBL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam int V_N   [NV] = '{20, 30, 25, 40, 10, 10, 12};
    localparam int V_EXP [NV] = '{20, 20, 20, 20, 10, 10, 12};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input bit use_alt);
        @(negedge clk);
        if (use_alt) alt_en = 1'b1; else ref_en = 1'b1;
        repeat (n) @(negedge clk);
        ref_en = 1'b0; alt_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tick", 64'(tick), 64'd0);
        chk("R1 count", count, 64'd0);
        chk("R1 step", 64'(step), 64'd1);

        // R2 latency at unity divisor
        @(negedge clk); ref_en = 1'b1;
        @(negedge clk); ref_en = 1'b0;
        chk("R2 tick after enable", 64'(tick), 64'd1);
        @(negedge clk);
        chk("R2 tick drops", 64'(tick), 64'd0);
        @(negedge clk);

        // R3 R4 R5 R8 table
        for (int i = 0; i < NV; i++) begin
            wr(4'h0, V_DBL[i] ? 32'h0000_0200 : 32'h0);
            wr(4'h8, V_DIV[i]);
            chk("R5 step value", 64'(step), V_DBL[i] ? 64'd2 : 64'd1);
            c0 = count;
            ticks_seen = 0;
            run(V_N[i], 1'b0);
            chk((V_DIV[i] < 32'h8000_0000) ? "R4 clamp ticks" : "R3 ratio ticks",
                64'(ticks_seen), 64'(V_EXP[i]));
            chk("R8 count delta", count - c0, 64'(V_EXP[i] * (V_DBL[i] ? 2 : 1)));
        end

        // R6 control 0 restores reference and step 1
        wr(4'h0, 32'h0);
        chk("R6 step after ctrl 0", 64'(step), 64'd1);

        // R7 divisor write clears phase
        wr(4'h8, 32'hC000_0000);
        ticks_seen = 0;
        run(1, 1'b0);
        wr(4'h8, 32'hC000_0000);
        run(1, 1'b0);
        chk("R7 cleared phase no tick", 64'(ticks_seen), 64'd0);
        run(1, 1'b0);
        chk("R7 tick after two", 64'(ticks_seen), 64'd1);

        // R7 write cycle with enable high gives no tick
        wr(4'h8, 32'h8000_0000);
        @(negedge clk);
        ref_en = 1'b1; wr_en = 1'b1; wr_addr = 4'h8; wr_data = 32'h8000_0000;
        @(negedge clk);
        ref_en = 1'b0; wr_en = 1'b0;
        chk("R7 no tick on write cycle", 64'(tick), 64'd0);

        // R6 source select
        wr(4'h0, 32'h0000_0100);
        ticks_seen = 0;
        run(5, 1'b0);
        chk("R6 ref ignored on alt", 64'(ticks_seen), 64'd0);
        run(5, 1'b1);
        chk("R6 alt drives", 64'(ticks_seen), 64'd5);
        wr(4'h0, 32'h0);
        ticks_seen = 0;
        run(4, 1'b1);
        chk("R6 alt ignored on ref", 64'(ticks_seen), 64'd0);

        // R9 unused address ignored
        wr(4'h4, 32'h0000_0300);
        wr(4'hC, 32'h0000_0000);
        chk("R9 step unchanged", 64'(step), 64'd1);
        ticks_seen = 0;
        run(6, 1'b0);
        chk("R9 ratio unchanged", 64'(ticks_seen), 64'd6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule